// File: doc/BRIEF.md
# Per-Core Idle State Controller

This block tracks the idle power state of one processor core that runs several hardware threads. Each thread may ask to idle through a halt, through a wait request carrying a depth hint, or through an I/O read of the power control block at one of two levels. Every request is held per thread until that thread is woken. The core only leaves the active state once every thread has a request pending, and it then goes to the shallowest state any thread asked for.

The controller runs the entry handshakes. The sleep state (code 3) needs a cache flush, and the deep sleep state (code 6) needs a state save. The core clock is stopped only after the matching done response arrives. Which events wake the core depends on the state and on how it was entered. Leaving deep sleep runs a restore handshake before the core reports itself active.

The resolved state goes to a package-level resolver as a 3-bit code with a one-cycle valid strobe.

Top module: `core_idle_ctrl`

## Requirements
- R1: While at least one thread has no pending idle request, the core stays active: core_state_o reads 0 and no handshake request is raised.
- R2: Once every thread has a pending request, the controller targets the shallowest requested state. Codes are C1=1, C3=3, C6=6. A halt or a wait with hint 0 asks for C1. A wait with hint 1 asks for C3. A wait with hint 2 or 3 asks for C6. An I/O read with level bit 0 asks for C3, and with level bit 1 asks for C6.
- R3: In C1, an interrupt always returns the core to C0. A monitor hit returns it only if at least one thread entered through a wait request. A monitor hit with only halted threads leaves the core in C1.
- R4: snoop_svc_o follows the external and sibling snoop inputs while the core clock runs. It is 0 while the clock is stopped. Snoops never change the state.
- R5: On the way to C3, flush_req_o stays high until flush_done_i. clk_stop_o rises and core_state_o reads 3 in the cycle after the done response, and not before.
- R6: In C3 only an interrupt wakes the core, in the cycle after it arrives. Snoops, sibling accesses and monitor hits leave it in C3.
- R7: On the way to C6, save_req_o stays high until save_done_i. clk_stop_o rises and core_state_o reads 6 in the cycle after the done response.
- R8: An interrupt in C6 raises restore_req_o with the clock running and core_state_o at 0. active_o stays low until the cycle after restore_done_i.
- R9: An interrupt during a flush or a save aborts the entry. The request is held until its done response, and the core then returns to C0 without stopping the clock.
- R10: state_vld_o is high for exactly the one cycle in which core_state_o takes a new value.
- R11: Asserting rst_ni low from any state returns the controller to C0 with every request output low and all thread requests cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| halt_i | input | N_THREADS | Per-thread halt request |
| wait_i | input | N_THREADS | Per-thread wait request |
| wait_hint_i | input | N_THREADS*HINT_W | Per-thread wait depth hint |
| io_rd_i | input | N_THREADS | Per-thread power control block read |
| io_lvl_i | input | N_THREADS | Read level: 0 sleep, 1 deep sleep |
| irq_i | input | 1 | Interrupt to the core |
| mon_hit_i | input | 1 | Write hit on the armed monitor address |
| snoop_i | input | 1 | External snoop |
| sib_snoop_i | input | 1 | Snoop or cacheable access from a sibling thread |
| flush_done_i | input | 1 | Cache flush complete |
| save_done_i | input | 1 | State save complete |
| restore_done_i | input | 1 | State restore complete |
| flush_req_o | output | 1 | Cache flush request |
| save_req_o | output | 1 | State save request |
| restore_req_o | output | 1 | State restore request |
| clk_stop_o | output | 1 | Core clock stop |
| snoop_svc_o | output | 1 | Snoop being serviced |
| active_o | output | 1 | Core active and ready |
| core_state_o | output | 3 | Resolved core state code |
| state_vld_o | output | 1 | One-cycle strobe on a state change |

## Verification
A per-thread register that loses or keeps a request wrongly shows up as a core that idles early or never idles. It appears at core_state_o two cycles after the thread requests. A wrong transition in the state machine shows up within one cycle of the responsible done or wake input: clk_stop_o rises before the flush or save completes, a request output stays high, or the core fails to leave sleep on an interrupt. A broken abort path shows as a stopped clock after an interrupt that came during an entry.

// File: rtl/core_idle_pkg.sv
package core_idle_pkg;
  typedef enum logic [2:0] {
    CST_C0 = 3'd0,
    CST_C1 = 3'd1,
    CST_C3 = 3'd3,
    CST_C6 = 3'd6
  } cstate_e;

  typedef enum logic [2:0] {
    ST_ACT, ST_HALT, ST_FLUSH, ST_SLEEP, ST_SAVE, ST_DEEP, ST_RESTORE
  } fsm_e;
endpackage

// File: rtl/core_idle_thread.sv
module core_idle_thread
  import core_idle_pkg::*;
#(
  parameter int unsigned HINT_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              halt_i,
  input  logic              wait_i,
  input  logic [HINT_W-1:0] wait_hint_i,
  input  logic              io_rd_i,
  input  logic              io_lvl_i,
  input  logic              wake_i,
  input  logic              mon_hit_i,
  output logic              pend_o,
  output cstate_e           lvl_o,
  output logic              armed_o
);
  cstate_e hint_lvl;

  always_comb begin
    if (wait_hint_i == '0)                    hint_lvl = CST_C1;
    else if (wait_hint_i == HINT_W'(1))       hint_lvl = CST_C3;
    else                                      hint_lvl = CST_C6;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_o  <= 1'b0;
      lvl_o   <= CST_C0;
      armed_o <= 1'b0;
    end else if (wake_i || (mon_hit_i && armed_o)) begin
      pend_o  <= 1'b0;
      lvl_o   <= CST_C0;
      armed_o <= 1'b0;
    end else if (halt_i) begin
      pend_o  <= 1'b1;
      lvl_o   <= CST_C1;
      armed_o <= 1'b0;
    end else if (wait_i) begin
      pend_o  <= 1'b1;
      lvl_o   <= hint_lvl;
      armed_o <= 1'b1;
    end else if (io_rd_i) begin
      pend_o  <= 1'b1;
      lvl_o   <= io_lvl_i ? CST_C6 : CST_C3;
      armed_o <= 1'b0;
    end
  end

  a_r11_pend_has_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_o |-> (lvl_o != CST_C0));
endmodule

// File: rtl/core_idle_resolve.sv
module core_idle_resolve
  import core_idle_pkg::*;
#(
  parameter int unsigned N_THREADS = 2
) (
  input  logic [N_THREADS-1:0]      pend_i,
  input  logic [N_THREADS-1:0][2:0] lvl_i,
  input  logic [N_THREADS-1:0]      armed_i,
  output cstate_e                   target_o,
  output logic                      any_armed_o
);
  logic [2:0] min_lvl;

  always_comb begin
    min_lvl = 3'd7;
    for (int i = 0; i < N_THREADS; i++)
      if (lvl_i[i] < min_lvl) min_lvl = lvl_i[i];
    target_o    = (&pend_i) ? cstate_e'(min_lvl) : CST_C0;
    any_armed_o = |armed_i;
  end
endmodule

// File: rtl/core_idle_fsm.sv
module core_idle_fsm
  import core_idle_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  cstate_e target_i,
  input  logic    any_armed_i,
  input  logic    irq_i,
  input  logic    mon_hit_i,
  input  logic    flush_done_i,
  input  logic    save_done_i,
  input  logic    restore_done_i,
  output logic    flush_req_o,
  output logic    save_req_o,
  output logic    restore_req_o,
  output logic    clk_stop_o,
  output logic    mon_en_o,
  output logic    active_o,
  output cstate_e code_o
);
  fsm_e st_q, st_d;
  logic abort_q;

  function automatic fsm_e enter(cstate_e t);
    case (t)
      CST_C1:  return ST_HALT;
      CST_C3:  return ST_FLUSH;
      CST_C6:  return ST_SAVE;
      default: return ST_ACT;
    endcase
  endfunction

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_ACT:     if (!irq_i) st_d = enter(target_i);
      ST_HALT: begin
        if (irq_i || (mon_hit_i && any_armed_i)) st_d = ST_ACT;
        else if (target_i != CST_C1)            st_d = enter(target_i);
      end
      ST_FLUSH:   if (flush_done_i) st_d = (abort_q || irq_i) ? ST_ACT : ST_SLEEP;
      ST_SLEEP:   if (irq_i) st_d = ST_ACT;
      ST_SAVE:    if (save_done_i) st_d = (abort_q || irq_i) ? ST_ACT : ST_DEEP;
      ST_DEEP:    if (irq_i) st_d = ST_RESTORE;
      ST_RESTORE: if (restore_done_i) st_d = ST_ACT;
      default:    st_d = ST_ACT;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_ACT;
      abort_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      abort_q <= (st_q == ST_FLUSH || st_q == ST_SAVE) && (st_d == st_q) && (abort_q || irq_i);
    end
  end

  always_comb begin
    flush_req_o   = (st_q == ST_FLUSH);
    save_req_o    = (st_q == ST_SAVE);
    restore_req_o = (st_q == ST_RESTORE);
    clk_stop_o    = (st_q == ST_SLEEP) || (st_q == ST_DEEP);
    mon_en_o      = (st_q == ST_ACT) || (st_q == ST_HALT);
    active_o      = (st_q == ST_ACT);
    case (st_q)
      ST_HALT:  code_o = CST_C1;
      ST_SLEEP: code_o = CST_C3;
      ST_DEEP:  code_o = CST_C6;
      default:  code_o = CST_C0;
    endcase
  end

  a_r5_no_stop_during_flush: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_FLUSH && !flush_done_i) |=> !clk_stop_o);
  a_r7_no_stop_during_save: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_SAVE && !save_done_i) |=> !clk_stop_o);
  a_r6_sleep_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_SLEEP && !irq_i) |=> (st_q == ST_SLEEP));
  a_r3_halt_irq_wakes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_HALT && irq_i) |=> active_o);
  a_r8_restore_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_RESTORE && !restore_done_i) |=> (restore_req_o && !active_o));
  a_r9_abort_returns: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (abort_q && ((st_q == ST_FLUSH && flush_done_i) || (st_q == ST_SAVE && save_done_i)))
    |=> (active_o && !clk_stop_o));
endmodule

// File: rtl/core_idle_ctrl.sv
module core_idle_ctrl
  import core_idle_pkg::*;
#(
  parameter int unsigned N_THREADS = 2,
  parameter int unsigned HINT_W    = 2
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [N_THREADS-1:0]         halt_i,
  input  logic [N_THREADS-1:0]         wait_i,
  input  logic [N_THREADS*HINT_W-1:0]  wait_hint_i,
  input  logic [N_THREADS-1:0]         io_rd_i,
  input  logic [N_THREADS-1:0]         io_lvl_i,
  input  logic                         irq_i,
  input  logic                         mon_hit_i,
  input  logic                         snoop_i,
  input  logic                         sib_snoop_i,
  input  logic                         flush_done_i,
  input  logic                         save_done_i,
  input  logic                         restore_done_i,
  output logic                         flush_req_o,
  output logic                         save_req_o,
  output logic                         restore_req_o,
  output logic                         clk_stop_o,
  output logic                         snoop_svc_o,
  output logic                         active_o,
  output logic [2:0]                   core_state_o,
  output logic                         state_vld_o
);
  logic [N_THREADS-1:0]      pend, armed;
  logic [N_THREADS-1:0][2:0] lvl;
  cstate_e target, code;
  logic    any_armed, mon_en;
  logic [2:0] code_q;

  for (genvar t = 0; t < N_THREADS; t++) begin : g_thr
    cstate_e lvl_t;
    core_idle_thread #(.HINT_W(HINT_W)) u_thr (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .halt_i     (halt_i[t]),
      .wait_i     (wait_i[t]),
      .wait_hint_i(wait_hint_i[t*HINT_W +: HINT_W]),
      .io_rd_i    (io_rd_i[t]),
      .io_lvl_i   (io_lvl_i[t]),
      .wake_i     (irq_i),
      .mon_hit_i  (mon_hit_i && mon_en),
      .pend_o     (pend[t]),
      .lvl_o      (lvl_t),
      .armed_o    (armed[t])
    );
    assign lvl[t] = lvl_t;
  end

  core_idle_resolve #(.N_THREADS(N_THREADS)) u_res (
    .pend_i     (pend),
    .lvl_i      (lvl),
    .armed_i    (armed),
    .target_o   (target),
    .any_armed_o(any_armed)
  );

  core_idle_fsm u_fsm (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .target_i      (target),
    .any_armed_i   (any_armed),
    .irq_i         (irq_i),
    .mon_hit_i     (mon_hit_i),
    .flush_done_i  (flush_done_i),
    .save_done_i   (save_done_i),
    .restore_done_i(restore_done_i),
    .flush_req_o   (flush_req_o),
    .save_req_o    (save_req_o),
    .restore_req_o (restore_req_o),
    .clk_stop_o    (clk_stop_o),
    .mon_en_o      (mon_en),
    .active_o      (active_o),
    .code_o        (code)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) code_q <= CST_C0;
    else         code_q <= code;
  end

  assign core_state_o = code;
  assign state_vld_o  = (code != code_q);
  assign snoop_svc_o  = (snoop_i || sib_snoop_i) && !clk_stop_o;

  a_r10_vld_on_change: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(core_state_o) |-> state_vld_o);
  a_r10_vld_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_vld_o |=> (!state_vld_o || !$stable(core_state_o)));
  a_r1_idle_needs_all: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_o && !(&pend)) |=> active_o);
endmodule

// File: tb/core_idle_ctrl_tb.sv
module core_idle_ctrl_tb;
  localparam int N = 2;
  localparam int HW = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [N-1:0] halt = '0, wt = '0, io_rd = '0, io_lvl = '0;
  logic [N*HW-1:0] hint = '0;
  logic irq = 0, mon = 0, snp = 0, sib = 0, fdone = 0, sdone = 0, rdone = 0;
  logic freq, sreq, rreq, cstop, svc, act, vld;
  logic [2:0] code;
  int n_chk = 0, n_err = 0;
  bit auto_rsp = 0, done_flag = 0;

  always #5 clk = ~clk;

  core_idle_ctrl #(.N_THREADS(N), .HINT_W(HW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .halt_i(halt), .wait_i(wt), .wait_hint_i(hint),
    .io_rd_i(io_rd), .io_lvl_i(io_lvl), .irq_i(irq), .mon_hit_i(mon),
    .snoop_i(snp), .sib_snoop_i(sib), .flush_done_i(fdone), .save_done_i(sdone),
    .restore_done_i(rdone), .flush_req_o(freq), .save_req_o(sreq),
    .restore_req_o(rreq), .clk_stop_o(cstop), .snoop_svc_o(svc), .active_o(act),
    .core_state_o(code), .state_vld_o(vld));

  task automatic chk(string req, int actual, int expv);
    n_chk++;
    if (actual !== expv) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", req, actual, expv);
    end
  endtask

  task automatic cyc(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // kind: 0 halt, 1..3 wait hint 0..2, 4 io level 0, 5 io level 1
  function automatic int kind_lvl(int k);
    case (k)
      0, 1: return 1;
      2, 4: return 3;
      default: return 6;
    endcase
  endfunction

  task automatic req(int t, int k);
    case (k)
      0: halt[t] = 1;
      1, 2, 3: begin wt[t] = 1; hint[t*HW +: HW] = HW'(k - 1); end
      default: begin io_rd[t] = 1; io_lvl[t] = (k == 5); end
    endcase
  endtask

  task automatic clr_req();
    halt = '0; wt = '0; io_rd = '0; io_lvl = '0; hint = '0;
  endtask

  task automatic pulse_irq();
    irq = 1; cyc(1); irq = 0;
  endtask

  // responder: done after three cycles of request
  initial begin
    int fc = 0, sc = 0, rc = 0;
    forever begin
      @(negedge clk);
      if (auto_rsp) begin
        if (freq) begin fdone = (fc == 2); fc = (fc == 2) ? 0 : fc + 1; end else begin fdone = 0; fc = 0; end
        if (sreq) begin sdone = (sc == 2); sc = (sc == 2) ? 0 : sc + 1; end else begin sdone = 0; sc = 0; end
        if (rreq) begin rdone = (rc == 2); rc = (rc == 2) ? 0 : rc + 1; end else begin rdone = 0; rc = 0; end
      end
    end
  end

  initial begin
    #(20000 * 10);
    n_err++;
    $display("FAIL watchdog: actual 1 expected 0");
    if (!done_flag) $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    cyc(3);
    // R11 reset state
    chk("R11 code", code, 0); chk("R11 req", {freq, sreq, rreq, cstop}, 0);
    rst_n = 1; cyc(2);
    chk("R11 active", act, 1);

    // R1 one thread only
    req(0, 0); cyc(1); clr_req(); cyc(4);
    chk("R1 stays C0", code, 0); chk("R1 no flush", freq, 0);
    req(1, 0); cyc(1); clr_req();
    chk("R10 no strobe yet", vld, 0);
    cyc(1);
    chk("R1 enters C1", code, 1); chk("R10 strobe", vld, 1);
    cyc(1); chk("R10 strobe one cycle", vld, 0);
    // R4 snoop serviced in C1, no state change
    snp = 1; cyc(1); chk("R4 svc in C1", svc, 1); chk("R4 stay C1", code, 1);
    snp = 0; sib = 1; cyc(1); chk("R4 sib svc in C1", svc, 1); sib = 0;
    // R3 halt entry: monitor hit ignored
    mon = 1; cyc(1); mon = 0; cyc(2);
    chk("R3 mon ignored after halt", code, 1);
    pulse_irq(); chk("R3 irq wakes", code, 0); chk("R3 active", act, 1);

    // R3 wait entry: monitor hit wakes
    req(0, 0); req(1, 1); cyc(1); clr_req(); cyc(1);
    chk("R2 halt+wait0 C1", code, 1);
    mon = 1; cyc(1); mon = 0;
    chk("R3 mon wakes", code, 0);
    pulse_irq(); cyc(1);

    // R5 flush handshake, R2 shallowest
    req(0, 5); req(1, 4); cyc(1); clr_req(); cyc(1);
    chk("R5 flush req", freq, 1); chk("R5 no stop", cstop, 0); chk("R2 code in flush", code, 0);
    cyc(3); chk("R5 held", freq, 1); chk("R5 still running", cstop, 0);
    fdone = 1; cyc(1); fdone = 0;
    chk("R5 stop after done", cstop, 1); chk("R5 code C3", code, 3); chk("R5 flush dropped", freq, 0);
    // R6 / R4 snoops and monitor in C3
    snp = 1; sib = 1; mon = 1; cyc(1);
    chk("R4 no svc stopped", svc, 0);
    cyc(1); snp = 0; sib = 0; mon = 0; cyc(1);
    chk("R6 stays C3", code, 3);
    pulse_irq(); chk("R6 irq wakes", code, 0); chk("R6 clock runs", cstop, 0);
    cyc(1);

    // R7 save handshake, R8 restore
    req(0, 3); req(1, 5); cyc(1); clr_req(); cyc(1);
    chk("R7 save req", sreq, 1); chk("R7 no stop", cstop, 0);
    cyc(2); sdone = 1; cyc(1); sdone = 0;
    chk("R7 code C6", code, 6); chk("R7 stop", cstop, 1);
    pulse_irq();
    chk("R8 restore req", rreq, 1); chk("R8 clock runs", cstop, 0);
    chk("R8 code 0", code, 0); chk("R8 not active", act, 0);
    cyc(2); chk("R8 still not active", act, 0);
    rdone = 1; cyc(1); rdone = 0;
    chk("R8 active after restore", act, 1); chk("R8 restore dropped", rreq, 0);

    // R9 abort during save
    req(0, 3); req(1, 3); cyc(1); clr_req(); cyc(1);
    chk("R9 saving", sreq, 1);
    pulse_irq();
    chk("R9 save held", sreq, 1); chk("R9 no stop", cstop, 0);
    cyc(2); sdone = 1; cyc(1); sdone = 0;
    chk("R9 back to C0", code, 0); chk("R9 clock runs", cstop, 0);
    chk("R9 active", act, 1); chk("R9 no restore", rreq, 0);
    cyc(2); chk("R9 stays C0", code, 0);

    // R9 abort during flush
    req(0, 2); req(1, 2); cyc(1); clr_req(); cyc(1);
    pulse_irq(); cyc(1); fdone = 1; cyc(1); fdone = 0;
    chk("R9 flush abort", cstop, 0); chk("R9 flush abort code", code, 0);

    // R11 reset from C3
    req(0, 4); req(1, 4); cyc(1); clr_req(); cyc(1); fdone = 1; cyc(1); fdone = 0;
    chk("R11 pre C3", code, 3);
    rst_n = 0; cyc(1);
    chk("R11 reset code", code, 0); chk("R11 reset stop", cstop, 0);
    rst_n = 1; cyc(3); chk("R11 threads cleared", code, 0);

    // random: R2 target and wake
    auto_rsp = 1;
    for (int trial = 0; trial < 60; trial++) begin
      int k0, k1, e;
      k0 = $urandom % 6; k1 = $urandom % 6;
      e = (kind_lvl(k0) < kind_lvl(k1)) ? kind_lvl(k0) : kind_lvl(k1);
      req(0, k0); req(1, k1); cyc(1); clr_req(); cyc(20);
      chk("R2 random level", code, e);
      chk("R2 random stop", cstop, (e > 1) ? 1 : 0);
      pulse_irq(); cyc(20);
      chk("R8 random wake", code, 0); chk("R8 random active", act, 1);
    end
    auto_rsp = 0;

    done_flag = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule